// File: doc/BRIEF.md
# Token-Chained Group Readout Slave

This block is the per-slave logic that lets several neighbouring slave modules answer one block read as if they were one module. Each slave keeps a role field (idle, first, middle or last) in its control register 0. The master attaches only the slave whose role is first and then runs a single block read. A token travels along point-to-point links from each slave to the next one. The slave that holds the token supplies words from its local FIFO, one word per data handshake.

A slave gives up the token once its FIFO is empty. A middle slave passes it to the next neighbour. The last slave raises end-of-block to the master instead. A slave with no data passes the token straight on. When address sync drops, every slave returns to waiting, so an aborted read leaves no token behind. Data words from all slaves meet on a wired-OR, so a slave drives zero whenever it is not presenting a word.

Top module: `chain_rd_slave`

## Requirements
- R1: After reset the role is idle and ack_o, tok_o, eob_o and word_vld_o are all low, with word_o zero.
- R2: A write on cfg_we_i loads cfg_role_i as the role (00 idle, 01 first, 10 middle, 11 last). The role keeps its value across any number of later transfers until the next write.
- R3: Only a slave whose role is first raises ack_o. It does so one cycle after a cycle with as_i and sel_i both high, and holds it while as_i stays high. Middle and last slaves never acknowledge, even when sel_i is high.
- R4: While it holds the token, each cycle with rd_req_i high pops one word, which appears on word_o with word_vld_o one cycle later, in FIFO order. A slave without the token outputs nothing on rd_req_i, and its FIFO is left untouched.
- R5: A first or middle slave raises tok_o once its FIFO is empty while it holds the token. It keeps tok_o high until as_i drops.
- R6: A middle or last slave takes the token when tok_i is high during a transfer. If its FIFO is empty, it hands the token on without supplying a word.
- R7: A last slave raises eob_o instead of tok_o when its FIFO is exhausted. tok_o and eob_o are never high together.
- R8: When as_i is low, the token state clears at the next edge (tok_o, eob_o and ack_o go low). Words that were not read stay in the FIFO for the next transfer.
- R9: An idle slave never takes the token, never outputs a word and keeps tok_o low.
- R10: A push into a full FIFO is dropped. The FIFO holds at most DEPTH words.
- R11: word_o is zero in every cycle in which word_vld_o is low, so that slaves can share a wired-OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the role field of control register 0 |
| cfg_role_i | input | 2 | Role value to write |
| push_i | input | 1 | Push a word into the local FIFO |
| push_data_i | input | WIDTH | Word to push |
| as_i | input | 1 | Address sync; high for the whole block transfer |
| sel_i | input | 1 | Primary address matches this slave |
| rd_req_i | input | 1 | Data handshake request, one word per cycle |
| tok_i | input | 1 | Token from the previous neighbour |
| ack_o | output | 1 | Address acknowledge (first slave only) |
| tok_o | output | 1 | Token to the next neighbour |
| eob_o | output | 1 | End of block (last slave only) |
| word_vld_o | output | 1 | word_o holds a delivered word |
| word_o | output | WIDTH | Read data, zero when not valid |

## Verification
The bench builds three instances (first, middle, last) with WIDTH 16 and DEPTH 4. A depth of four makes the full-FIFO drop reachable with a handful of pushes. It also lets one chain exercise ordered hand-off across slaves, a middle slave with no data, a read aborted by dropping address sync, and an idle member that breaks the chain. The merged wired-OR stream is compared against an order that the bench derives from its own stimulus table.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [1:0] {
    ROLE_IDLE  = 2'b00,
    ROLE_FIRST = 2'b01,
    ROLE_MID   = 2'b10,
    ROLE_LAST  = 2'b11
  } role_e;

  typedef enum logic [1:0] {
    TK_WAIT = 2'b00,
    TK_HOLD = 2'b01,
    TK_DONE = 2'b10
  } tok_st_e;
endpackage

// File: rtl/chain_role_reg.sv
module chain_role_reg
  import chain_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output role_e      role_o
);
  role_e role_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   role_q <= ROLE_IDLE;
    else if (we_i) role_q <= role_e'(wdata_i);
  end

  assign role_o = role_q;

  p_role_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(role_q));
endmodule

// File: rtl/chain_word_fifo.sv
module chain_word_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> cnt_q == $past(cnt_q));
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_pop_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/chain_token_ctl.sv
module chain_token_ctl
  import chain_rd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  role_e role_i,
  input  logic  as_i,
  input  logic  sel_i,
  input  logic  tok_i,
  input  logic  rd_req_i,
  input  logic  empty_i,
  output logic  pop_o,
  output logic  ack_o,
  output logic  tok_o,
  output logic  eob_o
);
  tok_st_e st_q, st_d;
  logic    attach_q;
  logic    grant;
  logic    is_first;

  assign is_first = (role_i == ROLE_FIRST);

  // first slave: granted by its own primary address; others: by neighbour token
  always_comb begin
    if (is_first)                grant = attach_q || sel_i;
    else if (role_i != ROLE_IDLE) grant = tok_i;
    else                         grant = 1'b0;
  end

  always_comb begin
    st_d = st_q;
    if (!as_i) st_d = TK_WAIT;
    else begin
      case (st_q)
        TK_WAIT: if (grant)   st_d = TK_HOLD;
        TK_HOLD: if (empty_i) st_d = TK_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= TK_WAIT;
      attach_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (!as_i)                 attach_q <= 1'b0;
      else if (sel_i && is_first) attach_q <= 1'b1;
    end
  end

  assign pop_o = (st_q == TK_HOLD) && as_i && rd_req_i && !empty_i;
  assign ack_o = attach_q;
  assign tok_o = (st_q == TK_DONE) && (role_i != ROLE_LAST);
  assign eob_o = (st_q == TK_DONE) && (role_i == ROLE_LAST);

  p_clear_on_as_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> (st_q == TK_WAIT && !ack_o));
  p_tok_eob_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tok_o && eob_o));
  p_ack_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(is_first && sel_i && as_i));
  p_pass_when_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tok_o) |-> $past(st_q == TK_HOLD && empty_i));
  p_idle_no_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TK_WAIT && role_i == ROLE_IDLE) |=> st_q == TK_WAIT);
endmodule

// File: rtl/chain_rd_slave.sv
module chain_rd_slave
  import chain_rd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_role_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             as_i,
  input  logic             sel_i,
  input  logic             rd_req_i,
  input  logic             tok_i,
  output logic             ack_o,
  output logic             tok_o,
  output logic             eob_o,
  output logic             word_vld_o,
  output logic [WIDTH-1:0] word_o
);
  role_e            role;
  logic             pop, empty, full;
  logic [WIDTH-1:0] head;
  logic             vld_q;
  logic [WIDTH-1:0] word_q;

  chain_role_reg u_role (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_role_i),
    .role_o  (role)
  );

  chain_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full)
  );

  chain_token_ctl u_tok (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .role_i   (role),
    .as_i     (as_i),
    .sel_i    (sel_i),
    .tok_i    (tok_i),
    .rd_req_i (rd_req_i),
    .empty_i  (empty),
    .pop_o    (pop),
    .ack_o    (ack_o),
    .tok_o    (tok_o),
    .eob_o    (eob_o)
  );

  // registered output stage; zero when idle for the shared wired-OR
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= pop;
      word_q <= pop ? head : '0;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  p_zero_when_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> word_o == '0);
  p_vld_needs_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(rd_req_i && as_i));
  p_full_unused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !empty);
endmodule

// File: tb/chain_rd_slave_test.sv
module chain_rd_slave_test;
  localparam int W = 16;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic         as_s, rd_req;
  logic [2:0]   push, sel, cfg_we, ack, tok, eob, vld;
  logic [1:0]   role_w [3];
  logic [W-1:0] pdata [3];
  logic [W-1:0] word [3];

  chain_rd_slave #(.WIDTH(W), .DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we[0]), .cfg_role_i(role_w[0]),
    .push_i(push[0]), .push_data_i(pdata[0]), .as_i(as_s), .sel_i(sel[0]),
    .rd_req_i(rd_req), .tok_i(1'b0), .ack_o(ack[0]), .tok_o(tok[0]),
    .eob_o(eob[0]), .word_vld_o(vld[0]), .word_o(word[0]));

  chain_rd_slave #(.WIDTH(W), .DEPTH(D)) u_mid (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we[1]), .cfg_role_i(role_w[1]),
    .push_i(push[1]), .push_data_i(pdata[1]), .as_i(as_s), .sel_i(sel[1]),
    .rd_req_i(rd_req), .tok_i(tok[0]), .ack_o(ack[1]), .tok_o(tok[1]),
    .eob_o(eob[1]), .word_vld_o(vld[1]), .word_o(word[1]));

  chain_rd_slave #(.WIDTH(W), .DEPTH(D)) u_last (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we[2]), .cfg_role_i(role_w[2]),
    .push_i(push[2]), .push_data_i(pdata[2]), .as_i(as_s), .sel_i(sel[2]),
    .rd_req_i(rd_req), .tok_i(tok[1]), .ack_o(ack[2]), .tok_o(tok[2]),
    .eob_o(eob[2]), .word_vld_o(vld[2]), .word_o(word[2]));

  // {slave index, data}
  localparam logic [17:0] STIM [8] = '{
    {2'd0, 16'hA001}, {2'd2, 16'hC001}, {2'd1, 16'hB001}, {2'd0, 16'hA002},
    {2'd2, 16'hC002}, {2'd1, 16'hB002}, {2'd0, 16'hA003}, {2'd1, 16'hB003}};

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int got [32];
  int ngot;
  int exp_w [32];
  int nexp;
  bit multi, nz_idle, ack_ok, ack_seen;
  bit [2:0] seen_tok;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_word(input int s, input logic [W-1:0] d);
    @(negedge clk);
    push[s] = 1'b1; pdata[s] = d;
    @(negedge clk);
    push[s] = 1'b0;
  endtask

  task automatic sample();
    if ($countones(vld) > 1) multi = 1'b1;
    if (vld != 3'b000) begin
      if (ngot < 32) got[ngot] = int'(word[0] | word[1] | word[2]);
      ngot++;
    end
    for (int i = 0; i < 3; i++) if (!vld[i] && word[i] != '0) nz_idle = 1'b1;
    seen_tok |= tok;
  endtask

  task automatic run_read(input int limit, output bit got_eob);
    got_eob = 1'b0; ngot = 0; multi = 0; nz_idle = 0; seen_tok = '0;
    ack_ok = 1'b0; ack_seen = 1'b0;
    @(negedge clk);
    as_s = 1'b1; sel = 3'b111; rd_req = 1'b1;
    for (int c = 0; c < limit && !got_eob; c++) begin
      @(negedge clk);
      sel = 3'b000;
      if (c == 0) begin
        ack_seen = 1'b1;
        ack_ok = (ack == 3'b001);
      end
      sample();
      if (eob[2]) got_eob = 1'b1;
    end
    as_s = 1'b0; rd_req = 1'b0;
  endtask

  task automatic cmp_stream(input string req);
    check(ngot == nexp, req, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(got[i] == exp_w[i], req, got[i], exp_w[i]);
  endtask

  task automatic after_drop(input string req);
    @(negedge clk);
    check(tok == 3'b000 && eob == 3'b000 && ack == 3'b000, req,
          int'({ack, tok, eob}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit eb;
    rst_n = 1'b0; as_s = 0; rd_req = 0; push = '0; sel = '0; cfg_we = '0;
    for (int i = 0; i < 3; i++) begin role_w[i] = '0; pdata[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ack == 0 && tok == 0 && eob == 0 && vld == 0, "R1 outputs",
          int'({ack, tok, eob, vld}), 0);
    check((word[0] | word[1] | word[2]) == '0, "R1 word", int'(word[0] | word[1] | word[2]), 0);
    rst_n = 1'b1;

    // R2 roles: 01 first, 10 middle, 11 last
    @(negedge clk);
    cfg_we = 3'b111; role_w[0] = 2'b01; role_w[1] = 2'b10; role_w[2] = 2'b11;
    @(negedge clk);
    cfg_we = 3'b000;

    // table walk: load FIFOs, derive expected order per slave
    for (int i = 0; i < 8; i++) push_word(int'(STIM[i][17:16]), STIM[i][15:0]);
    nexp = 0;
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 8; i++)
        if (int'(STIM[i][17:16]) == s) begin exp_w[nexp] = int'(STIM[i][15:0]); nexp++; end

    // R4 request without token (no primary address) yields nothing
    ngot = 0; multi = 0; nz_idle = 0; seen_tok = '0;
    @(negedge clk); as_s = 1'b1; rd_req = 1'b1;
    for (int c = 0; c < 4; c++) begin @(negedge clk); sample(); end
    as_s = 1'b0; rd_req = 1'b0;
    check(ngot == 0, "R4 no token no data", ngot, 0);
    @(negedge clk);

    // full group read
    run_read(100, eb);
    check(ack_seen && ack_ok, "R3 only first acks", int'(ack), 1);
    cmp_stream("R4 stream order");
    check(eb, "R7 eob from last", int'(eb), 1);
    check(!seen_tok[2], "R7 last never passes token", int'(seen_tok[2]), 0);
    check(seen_tok[0] && seen_tok[1], "R5 token passed", int'(seen_tok), 3);
    check(!multi, "R4 single driver", int'(multi), 0);
    check(!nz_idle, "R11 zero when not valid", int'(nz_idle), 0);
    after_drop("R8 cleared after as low");

    // R2 roles kept; R6 empty middle forwards
    push_word(0, 16'h1111); push_word(0, 16'h2222); push_word(2, 16'h3333);
    exp_w[0] = 'h1111; exp_w[1] = 'h2222; exp_w[2] = 'h3333; nexp = 3;
    run_read(100, eb);
    check(ack_ok, "R2 role kept first acks", int'(ack_ok), 1);
    cmp_stream("R6 empty middle skipped");
    check(eb && seen_tok[1], "R6 middle forwarded", int'({eb, seen_tok[1]}), 3);
    after_drop("R8 cleared second");

    // R8 abort mid-read, remainder delivered later
    push_word(0, 16'h4441); push_word(0, 16'h4442); push_word(0, 16'h4443);
    push_word(2, 16'h5551);
    ngot = 0;
    @(negedge clk); as_s = 1'b1; sel = 3'b001; rd_req = 1'b1;
    for (int c = 0; c < 20 && ngot == 0; c++) begin
      @(negedge clk); sel = 3'b000; sample();
    end
    as_s = 1'b0; rd_req = 1'b0;
    check(ngot == 1 && got[0] == 'h4441, "R8 one word before abort", got[0], 'h4441);
    after_drop("R8 abort clears token");
    exp_w[0] = 'h4442; exp_w[1] = 'h4443; exp_w[2] = 'h5551; nexp = 3;
    run_read(100, eb);
    cmp_stream("R8 remainder kept");
    check(eb, "R7 eob after resume", int'(eb), 1);

    // R10 full FIFO drops extra pushes
    for (int i = 0; i < D + 2; i++) push_word(0, W'(16'h0100 + i));
    nexp = D;
    for (int i = 0; i < D; i++) exp_w[i] = 'h0100 + i;
    run_read(100, eb);
    cmp_stream("R10 overflow dropped");

    // R9 idle middle breaks chain
    @(negedge clk); cfg_we = 3'b010; role_w[1] = 2'b00;
    @(negedge clk); cfg_we = 3'b000;
    push_word(0, 16'h7777); push_word(1, 16'h8888);
    run_read(30, eb);
    check(ngot == 1 && got[0] == 'h7777, "R9 idle gives no word", ngot, 1);
    check(!seen_tok[1] && !eb, "R9 idle keeps tok low", int'({seen_tok[1], eb}), 0);
    after_drop("R8 cleared idle case");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule